// File: doc/BRIEF.md
# A24 Address Window Decoder

This block sits behind a bus slave interface and classifies each 24-bit access. It checks whether the access falls inside a 1 MB window whose base is set by a programmable offset register. If it does, the block steers the access to one of four targets. The targets are the short-address register set, a fixed window onto an internal word-addressed DSP bus, the streaming send/receive data port, and a paged 512 kB window onto the same DSP bus. For the two DSP windows it produces the translated DSP-bus address.

Three small configuration registers are written through a narrow write port. The control register holds the window enable, the offset register holds the base nibble, and the page map register holds the 8-bit page of the movable window. Each access presented on `acc_valid` gets a one-cycle registered result. The result is a hit with a target code, or a bus error when the window is disabled or the access type is not allowed in the region it addresses.

Top module: `a24_window_decoder`

## Requirements
- R1: After synchronous reset, the control, offset and page map readbacks are all zero, and hit, bus_err, tgt, dsp_en, dsp_addr and reg_idx are all zero.
- R2: cfg_sel selects the written register: 0 is control, 1 is offset, 2 is page map, and 3 is ignored. The offset readback keeps bits 15:12 of the last written value with bits 11:0 at zero. The page map readback keeps bits 7:0 with bits 15:8 at zero. The control readback keeps only bit 15.
- R3: An access whose address bits 23:20 differ from offset bits 15:12 raises neither hit nor bus_err.
- R4: An access that matches the base while control bit 15 is clear raises bus_err and not hit.
- R5: Window byte offsets 0x00000–0x0003F give tgt=0 (register set), with reg_idx equal to offset bits 5:0.
- R6: A longword access (acc_long=1) to offsets 0x0–0xF raises bus_err. Longword access to 0x10–0x3F is accepted.
- R7: Offsets 0x00040–0x1FFFF and 0x30000–0x7FFFF give tgt=1 (fixed DSP window), dsp_en=1, and dsp_addr bits 16:0 equal to offset bits 18:2, with all higher bits zero.
- R8: Offsets 0x20000–0x2FFFF give tgt=2 (data port), with dsp_en=0 and dsp_addr=0.
- R9: Offsets 0x80000–0xFFFFF give tgt=3 (paged DSP window), dsp_en=1, and dsp_addr bits 16:0 equal to offset bits 18:2. Page bits 5:0 drive dsp_addr 22:17, page bit 6 drives both dsp_addr 24 and 30, page bit 7 drives dsp_addr 31, and the other bits are zero.
- R10: A block transfer (acc_block=1) outside the data-port region raises bus_err.
- R11: Results appear exactly one clock after the access is sampled. A cycle with no access yields hit=0 and bus_err=0. Whenever hit=0, tgt, dsp_en, dsp_addr and reg_idx are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| ctrl_rd | output | 16 | Control register readback |
| offset_rd | output | 16 | Offset register readback |
| pagemap_rd | output | 16 | Page map register readback |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 24 | Byte address of the access |
| acc_long | input | 1 | Access is a 32-bit longword |
| acc_block | input | 1 | Access is part of a block transfer |
| hit | output | 1 | Access accepted, target valid |
| bus_err | output | 1 | Access matched but was refused |
| tgt | output | 2 | Target code: 0 regs, 1 fixed DSP, 2 data, 3 paged DSP |
| dsp_en | output | 1 | DSP bus access enable |
| dsp_addr | output | 32 | Translated DSP word address |
| reg_idx | output | 6 | Byte index into the register set |

## Verification
The hardest cases to reach from the ports depend on several settings at once. The paged translation needs a chosen page value and also an enabled window at a matching base. The two refusal rules, longword access to the low sixteen bytes and block transfers outside the data port, only show up inside an enabled, matching window. The bench first writes a base nibble and sets the enable. It then sweeps the whole 1 MB window in 1 KB steps with a changing low-address pattern and rotating longword and block flags. It walks all 256 page values through the movable window and covers every byte of the register set in both widths. Finally it moves the base and clears the enable to check that mismatched and disabled accesses are handled.

// File: rtl/a24dec_pkg.sv
package a24dec_pkg;
  typedef enum logic [1:0] {
    TGT_REGS      = 2'd0,
    TGT_DSP_FIXED = 2'd1,
    TGT_DATA      = 2'd2,
    TGT_DSP_PAGED = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    CFG_CTRL   = 2'd0,
    CFG_OFFSET = 2'd1,
    CFG_PAGE   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/a24_cfg_regs.sv
module a24_cfg_regs #(
  parameter int REG_W  = 16,
  parameter int BASE_W = 4,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [BASE_W-1:0] base_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              win_en_q,
  output logic [REG_W-1:0]  ctrl_rd,
  output logic [REG_W-1:0]  offset_rd,
  output logic [REG_W-1:0]  pagemap_rd
);
  import a24dec_pkg::*;

  localparam int EN_BIT = REG_W - 1;
  localparam int LOW_ZERO_W = REG_W - BASE_W;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata[LOW_ZERO_W-1:PAGE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      page_q   <= '0;
      win_en_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_CTRL:   win_en_q <= cfg_wdata[EN_BIT];
        CFG_OFFSET: base_q   <= cfg_wdata[REG_W-1:LOW_ZERO_W];
        CFG_PAGE:   page_q   <= cfg_wdata[PAGE_W-1:0];
        default:    ;
      endcase
    end
  end

  assign ctrl_rd    = {win_en_q, {(REG_W-1){1'b0}}};
  assign offset_rd  = {base_q, {LOW_ZERO_W{1'b0}}};
  assign pagemap_rd = {{(REG_W-PAGE_W){1'b0}}, page_q};
endmodule

// File: rtl/a24_region_decode.sv
module a24_region_decode #(
  parameter int WIN_W = 20
) (
  input  logic [WIN_W-1:0] off,
  input  logic             is_long,
  input  logic             is_block,
  output logic [1:0]       tgt,
  output logic             reject
);
  import a24dec_pkg::*;

  localparam logic [WIN_W-1:0] REGS_END   = WIN_W'(20'h0003F);
  localparam logic [WIN_W-1:0] NOLONG_END = WIN_W'(20'h0000F);
  localparam logic [WIN_W-1:0] DATA_LO    = WIN_W'(20'h20000);
  localparam logic [WIN_W-1:0] DATA_HI    = WIN_W'(20'h2FFFF);
  localparam logic [WIN_W-1:0] PAGED_LO   = WIN_W'(20'h80000);

  tgt_e t;

  always_comb begin
    reject = 1'b0;
    t      = TGT_DSP_FIXED;
    if (off <= REGS_END) begin
      t = TGT_REGS;
      if (is_long && off <= NOLONG_END) reject = 1'b1;
    end else if (off >= DATA_LO && off <= DATA_HI) begin
      t = TGT_DATA;
    end else if (off >= PAGED_LO) begin
      t = TGT_DSP_PAGED;
    end
    if (is_block && t != TGT_DATA) reject = 1'b1;
  end

  assign tgt = t;
endmodule

// File: rtl/a24_addr_xlate.sv
module a24_addr_xlate #(
  parameter int WIN_W    = 20,
  parameter int DSP_AW   = 32,
  parameter int PAGE_W   = 8,
  parameter int WORD_LSB = 2
) (
  input  logic [WIN_W-1:0]  off,
  input  logic [PAGE_W-1:0] page,
  input  logic [1:0]        tgt,
  output logic              dsp_en,
  output logic [DSP_AW-1:0] dsp_addr
);
  import a24dec_pkg::*;

  localparam int LOW_W     = WIN_W - 1 - WORD_LSB;
  localparam int PAGE_LINE = LOW_W;
  localparam int DUAL_LO   = 24;
  localparam int DUAL_HI   = 30;
  localparam int TOP_LINE  = 31;

  logic unused_off_bits;
  assign unused_off_bits = ^{off[WIN_W-1], off[WORD_LSB-1:0]};

  always_comb begin
    dsp_en   = (tgt == TGT_DSP_FIXED) || (tgt == TGT_DSP_PAGED);
    dsp_addr = '0;
    if (dsp_en) dsp_addr[LOW_W-1:0] = off[LOW_W+WORD_LSB-1:WORD_LSB];
    if (tgt == TGT_DSP_PAGED) begin
      for (int i = 0; i < PAGE_W; i++) begin
        if (i < 6) begin
          dsp_addr[PAGE_LINE+i] = page[i];
        end else if (i == 6) begin
          dsp_addr[DUAL_LO] = page[i];
          dsp_addr[DUAL_HI] = page[i];
        end else begin
          dsp_addr[TOP_LINE] = page[i];
        end
      end
    end
  end
endmodule

// File: rtl/a24_window_decoder.sv
module a24_window_decoder #(
  parameter int ADDR_W   = 24,
  parameter int WIN_W    = 20,
  parameter int REG_W    = 16,
  parameter int DSP_AW   = 32,
  parameter int PAGE_W   = 8,
  parameter int IDX_W    = 6,
  parameter int WORD_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  ctrl_rd,
  output logic [REG_W-1:0]  offset_rd,
  output logic [REG_W-1:0]  pagemap_rd,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_long,
  input  logic              acc_block,
  output logic              hit,
  output logic              bus_err,
  output logic [1:0]        tgt,
  output logic              dsp_en,
  output logic [DSP_AW-1:0] dsp_addr,
  output logic [IDX_W-1:0]  reg_idx
);
  import a24dec_pkg::*;

  localparam int BASE_W = ADDR_W - WIN_W;

  logic [BASE_W-1:0] base_q;
  logic [PAGE_W-1:0] page_q;
  logic              win_en_q;
  logic [WIN_W-1:0]  off;
  logic [1:0]        tgt_c;
  logic              reject_c;
  logic              dsp_en_c;
  logic [DSP_AW-1:0] dsp_addr_c;
  logic              match_c;
  logic              hit_c;
  logic              err_c;

  a24_cfg_regs #(.REG_W(REG_W), .BASE_W(BASE_W), .PAGE_W(PAGE_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .page_q(page_q),
    .win_en_q(win_en_q), .ctrl_rd(ctrl_rd), .offset_rd(offset_rd),
    .pagemap_rd(pagemap_rd)
  );

  assign off = acc_addr[WIN_W-1:0];

  a24_region_decode #(.WIN_W(WIN_W)) u_dec (
    .off(off), .is_long(acc_long), .is_block(acc_block),
    .tgt(tgt_c), .reject(reject_c)
  );

  a24_addr_xlate #(.WIN_W(WIN_W), .DSP_AW(DSP_AW), .PAGE_W(PAGE_W),
                   .WORD_LSB(WORD_LSB)) u_xl (
    .off(off), .page(page_q), .tgt(tgt_c),
    .dsp_en(dsp_en_c), .dsp_addr(dsp_addr_c)
  );

  assign match_c = acc_valid && (acc_addr[ADDR_W-1:WIN_W] == base_q);
  assign hit_c   = match_c && win_en_q && !reject_c;
  assign err_c   = match_c && (!win_en_q || reject_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      bus_err  <= 1'b0;
      tgt      <= '0;
      dsp_en   <= 1'b0;
      dsp_addr <= '0;
      reg_idx  <= '0;
    end else begin
      hit      <= hit_c;
      bus_err  <= err_c;
      tgt      <= hit_c ? tgt_c : 2'd0;
      dsp_en   <= hit_c && dsp_en_c;
      dsp_addr <= hit_c ? dsp_addr_c : '0;
      reg_idx  <= (hit_c && tgt_c == TGT_REGS) ? off[IDX_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/a24_window_decoder_chk.sv
module a24_window_decoder_chk #(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 16,
  parameter int DSP_AW = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  ctrl_rd,
  input logic [REG_W-1:0]  offset_rd,
  input logic [REG_W-1:0]  pagemap_rd,
  input logic              acc_valid,
  input logic              acc_long,
  input logic              acc_block,
  input logic              hit,
  input logic              bus_err,
  input logic [1:0]        tgt,
  input logic              dsp_en,
  input logic [DSP_AW-1:0] dsp_addr,
  input logic [IDX_W-1:0]  reg_idx
);
  assert_readback_zero_R2: assert property (@(posedge clk) disable iff (rst)
    offset_rd[11:0] == 12'h0 && pagemap_rd[15:8] == 8'h0);

  assert_disabled_no_hit_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_rd[REG_W-1]) |-> !hit);

  assert_hit_err_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(hit && bus_err));

  assert_no_long_low_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && tgt == 2'd0 && reg_idx < 6'd16) |-> !$past(acc_long));

  assert_fixed_high_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && tgt == 2'd1) |-> (dsp_en && dsp_addr[DSP_AW-1:17] == '0));

  assert_data_no_dsp_R8: assert property (@(posedge clk) disable iff (rst)
    (hit && tgt == 2'd2) |-> !dsp_en);

  assert_dual_line_R9: assert property (@(posedge clk) disable iff (rst)
    (hit && tgt == 2'd3) |-> (dsp_addr[30] == dsp_addr[24] && dsp_en));

  assert_block_only_data_R10: assert property (@(posedge clk) disable iff (rst)
    (hit && tgt != 2'd2) |-> !$past(acc_block));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid) |-> (!hit && !bus_err));
endmodule

bind a24_window_decoder a24_window_decoder_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .DSP_AW(DSP_AW), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/a24_window_decoder_bench.sv
`timescale 1ns/1ps
module a24_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] ctrl_rd, offset_rd, pagemap_rd;
  logic        acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        acc_long = 1'b0;
  logic        acc_block = 1'b0;
  logic        hit, bus_err, dsp_en;
  logic [1:0]  tgt;
  logic [31:0] dsp_addr;
  logic [5:0]  reg_idx;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] m_base = 4'h0;
  logic       m_en   = 1'b0;
  logic [7:0] m_page = 8'h0;

  always #2.5 clk = ~clk;

  a24_window_decoder u_a24_window_decoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_rd(ctrl_rd), .offset_rd(offset_rd),
    .pagemap_rd(pagemap_rd), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_long(acc_long), .acc_block(acc_block), .hit(hit), .bus_err(bus_err),
    .tgt(tgt), .dsp_en(dsp_en), .dsp_addr(dsp_addr), .reg_idx(reg_idx)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    if (sel == 2'd0) m_en = d[15];
    if (sel == 2'd1) m_base = d[15:12];
    if (sel == 2'd2) m_page = d[7:0];
  endtask

  task automatic model(input logic [23:0] a, input bit lng, input bit blk,
                       output logic [63:0] exp, output string tag);
    logic [19:0] o;
    logic e_hit, e_err, e_en;
    logic [1:0] e_tgt;
    logic [31:0] e_addr;
    logic [5:0] e_idx;
    int region;
    o = a[19:0];
    e_hit = 0; e_err = 0; e_en = 0; e_tgt = 0; e_addr = 0; e_idx = 0;
    if (o < 20'h40) region = 0;
    else if (o >= 20'h20000 && o < 20'h30000) region = 2;
    else if (o >= 20'h80000) region = 3;
    else region = 1;
    if (a[23:20] != m_base) tag = "R3";
    else if (!m_en) begin tag = "R4"; e_err = 1; end
    else if (blk && region != 2) begin tag = "R10"; e_err = 1; end
    else if (lng && o < 20'h10) begin tag = "R6"; e_err = 1; end
    else begin
      e_hit = 1;
      e_tgt = 2'(region);
      case (region)
        0: begin tag = "R5"; e_idx = o[5:0]; end
        1: begin tag = "R7"; e_en = 1; e_addr = (32'(o) >> 2) & 32'h1FFFF; end
        2: begin tag = "R8"; end
        default: begin
          tag = "R9"; e_en = 1;
          e_addr = ((32'(o) >> 2) & 32'h1FFFF)
                 | ((32'(m_page) & 32'h3F) << 17)
                 | (((32'(m_page) >> 6) & 32'h1) << 24)
                 | (((32'(m_page) >> 6) & 32'h1) << 30)
                 | ((32'(m_page) >> 7) << 31);
        end
      endcase
    end
    exp = {21'd0, e_hit, e_err, e_tgt, e_en, e_addr, e_idx};
  endtask

  task automatic access(input logic [23:0] a, input bit lng, input bit blk);
    logic [63:0] exp;
    string tag;
    model(a, lng, blk, exp, tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_long = lng; acc_block = blk;
    @(negedge clk);
    acc_valid = 1'b0;
    check(tag, {21'd0, hit, bus_err, tgt, dsp_en, dsp_addr, reg_idx}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", {ctrl_rd, offset_rd, pagemap_rd}, 64'h0);
    check("R1", {21'd0, hit, bus_err, tgt, dsp_en, dsp_addr, reg_idx}, 64'h0);
    // R4: base 0 matches, window still disabled
    access(24'h012345, 0, 0);
    // R11: idle cycle after access is quiet
    @(negedge clk);
    check("R11", {62'd0, hit, bus_err}, 64'h0);

    // R2: readback masking and select decoding
    cfg_write(2'd1, 16'hFFFF);
    check("R2", 64'(offset_rd), 64'hF000);
    cfg_write(2'd2, 16'hABCD);
    check("R2", 64'(pagemap_rd), 64'h00CD);
    cfg_write(2'd0, 16'h7FFF);
    check("R2", 64'(ctrl_rd), 64'h0000);
    cfg_write(2'd3, 16'h1234);
    check("R2", {ctrl_rd, offset_rd, pagemap_rd}, {16'h0, 16'hF000, 16'h00CD});

    cfg_write(2'd1, 16'hA5A5);
    check("R2", 64'(offset_rd), 64'hA000);
    cfg_write(2'd0, 16'h8000);
    check("R2", 64'(ctrl_rd), 64'h8000);
    cfg_write(2'd2, 16'h0000);

    // R5/R6: every register byte in both widths
    for (int i = 0; i < 72; i++) begin
      access({4'hA, 20'(i)}, 0, 0);
      access({4'hA, 20'(i)}, 1, 0);
    end
    // Boundary addresses around each region edge
    access(24'hA1FFFC, 0, 0);
    access(24'hA20000, 0, 0);
    access(24'hA2FFFF, 0, 0);
    access(24'hA30000, 0, 0);
    access(24'hA7FFFC, 0, 0);
    access(24'hA80000, 0, 0);
    access(24'hAFFFFF, 1, 0);
    access(24'hA20010, 1, 1);
    access(24'hA30000, 0, 1);

    // Whole-window sweep with rotating flags (R7, R8, R9, R10)
    cfg_write(2'd2, 16'h005A);
    for (int i = 0; i < 1024; i++) begin
      access({4'hA, 20'(i << 10) | 20'((i * 13) & 32'h3FC)}, i[0], i[1] & i[2]);
    end

    // R9: every page value through the movable window
    for (int p = 0; p < 256; p++) begin
      cfg_write(2'd2, 16'(p));
      access({4'hA, 20'h80000 | 20'((p * 4093) & 32'h7FFFC)}, 0, 0);
    end

    // R3: mismatching bases across all nibbles
    for (int b = 0; b < 16; b++) begin
      access({4'(b), 20'h81234}, 0, 0);
    end

    // R4: disabled window refuses every region
    cfg_write(2'd0, 16'h0000);
    access(24'hA00020, 0, 0);
    access(24'hA24000, 0, 0);
    access(24'hA90000, 0, 0);
    access(24'h590000, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule